// File: doc/BRIEF.md
# Compressed Branch Target Decoder

This block rebuilds the full 32-bit target of a branch packet from an instruction-trace byte stream. The bytes of one packet arrive one at a time on a valid/ready interface. The address is sent as a variable-length code of 7-bit groups. Only the low-order groups that changed are sent, so the block fills the missing upper bits from the previous branch target it holds. The result is then aligned to the processor's instruction state: 32-bit, 16-bit compressed or bytecode. A fifth address byte can switch that state.

Depending on an encoding-select input, the address may be followed by an exception-information field. The block decodes that field into an exception number, cancel, alternate-ISA, hypervisor, resume and non-secure outputs. A single-cycle `done` strobe marks a completed packet. Separate error strobes report an illegal state byte and an over-long field. A reference-address load, for example from a periodic synchronisation packet, reseeds the previous-target register. Telling packet types apart and finding sync in the stream are left to the surrounding logic.

Top module: `branch_addr_decoder`

## Requirements
- R1: Each accepted byte contributes bits [6:0] as the next 7-bit group, least significant group first. Bit 7 set means another address byte follows. The packet completes on the first byte with bit 7 clear, and `done` is high for exactly the cycle after that byte is accepted (when no exception field follows).
- R2: Target bits above the effective received width are copied from the previous-target register. That register is reloaded with `ref_addr` while `ref_load` is high, and with every completed target. `in_ready` is low while `ref_load` is high.
- R3: With received payload P (bits above the received width cleared), the result and the effective width depend on the state. State 0 (32-bit) gives (P with bit 0 cleared) shifted left by one, width +1. State 1 (compressed) gives P with bit 0 cleared, width unchanged. State 2 (bytecode) gives P with bit 0 cleared and shifted right by one, width −1.
- R4: When the address is five bytes long, the fifth byte sets the state, which appears on `isa_state` (0 = 32-bit, 1 = compressed, 2 = bytecode). Under mask 0xB8, a value of 0x08 selects state 0. Otherwise, under mask 0xB0, a value of 0x10 selects state 1. Otherwise, under mask 0xA0, a value of 0x20 selects state 2. Shorter addresses leave the state unchanged.
- R5: A fifth byte matching none of the R4 patterns pulses `err_state` one cycle after it is accepted. No `done` follows, and the state and previous target are unchanged.
- R6: With `enc_alt` = 1, the received width is 7·n−1. For n ≥ 2, received bit 7·n−1 set means an exception field follows. That bit is never part of the address.
- R7: With `enc_alt` = 0, the received width is 7·n. An exception field follows only when n = 5 and bit 6 of the fifth byte is set.
- R8: The exception field is gathered with the same continuation code into a value V. The outputs are: non-secure = V[0], number = {V[11:7], V[4:1]}, cancel = V[5], alternate ISA = V[6], hypervisor = V[12], resume = V[17:14]. When a field follows, `done` and `exc_valid` pulse together in the cycle after its last byte. The address outputs are those of the same packet.
- R9: If the exception field is exactly two bytes long and V[13] is set, V[13:7] is moved to V[20:14] before the fields are extracted.
- R10: A fifth address byte or a fourth exception byte with bit 7 set pulses `err_overflow` one cycle later, produces no `done`, and returns the block to expect a new address.
- R11: Reset clears the previous target to 0, sets state 0, and drives `done`, `exc_valid` and both error strobes low, with `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_alt | input | 1 | Encoding select: 1 = alternative, 0 = original |
| ref_load | input | 1 | Load the previous-target register from `ref_addr` |
| ref_addr | input | 32 | Reference target address |
| in_valid | input | 1 | Byte present on `in_byte` |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| in_byte | input | 8 | Packet byte |
| done | output | 1 | Packet completed (one cycle) |
| branch_addr | output | 32 | Rebuilt target address |
| isa_state | output | 2 | Instruction state after the packet |
| exc_valid | output | 1 | Exception fields belong to this `done` |
| exc_num | output | 9 | Exception number |
| exc_cancel | output | 1 | Instruction cancelled flag |
| exc_alt_isa | output | 1 | Alternate ISA flag |
| exc_hyp | output | 1 | Hypervisor flag |
| exc_resume | output | 4 | Resume value |
| exc_non_secure | output | 1 | Non-secure flag |
| err_state | output | 1 | Illegal fifth-byte state pattern |
| err_overflow | output | 1 | Field longer than allowed |

## Verification
The assertions assume that `enc_alt` is held steady from a packet's first byte to its last. They also assume that reset is held for at least one clock edge, so that the state register has a defined value before the first comparison against its past. The bench changes the encoding only between packets, and it raises `ref_load` only between packets, in its own cycle. It keeps the state-change assertion meaningful by sending every state switch as a separate five-byte packet.

// File: rtl/brdec_pkg.sv
package brdec_pkg;

    localparam int ADDR_W         = 32;
    localparam int GROUP_W        = 7;
    localparam int MAX_ADDR_BYTES = 5;
    localparam int ADDR_ACC_W     = GROUP_W * MAX_ADDR_BYTES;
    localparam int WIDE_W         = ADDR_ACC_W + 1;
    localparam int EXC_NUM_W      = 9;
    localparam int RESUME_W       = 4;
    localparam int EXC_WORK_W     = 32;

    typedef enum logic [1:0] {
        ISA_WORD  = 2'd0,
        ISA_HALF  = 2'd1,
        ISA_BYTE  = 2'd2
    } isa_e;

    typedef struct packed {
        logic                  non_secure;
        logic [EXC_NUM_W-1:0]  num;
        logic                  cancel;
        logic                  alt_isa;
        logic                  hyp;
        logic [RESUME_W-1:0]   resume;
    } exc_info_t;

    typedef struct packed {
        logic ok;
        isa_e isa;
    } isa_dec_t;

    // Classify the fifth address byte into an instruction state.
    function automatic isa_dec_t decode_isa_byte(input logic [7:0] b, input isa_e cur);
        isa_dec_t r;
        r.ok  = 1'b1;
        r.isa = cur;
        if ((b & 8'hB8) == 8'h08)      r.isa = ISA_WORD;
        else if ((b & 8'hB0) == 8'h10) r.isa = ISA_HALF;
        else if ((b & 8'hA0) == 8'h20) r.isa = ISA_BYTE;
        else                           r.ok  = 1'b0;
        return r;
    endfunction

    // Ones at every bit position at or above w.
    function automatic logic [ADDR_W-1:0] upper_mask(input logic [5:0] w);
        if (w >= 6'(ADDR_W)) return '0;
        return {ADDR_W{1'b1}} << w;
    endfunction

endpackage

// File: rtl/brdec_gather.sv
module brdec_gather #(
    parameter int MAX_BYTES = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               clear,
    input  logic                               push,
    input  logic [7:0]                         din,
    output logic [7*MAX_BYTES-1:0]             acc_nx,
    output logic [$clog2(MAX_BYTES+1)-1:0]     cnt_q,
    output logic [$clog2(MAX_BYTES+1)-1:0]     cnt_nx
);
    localparam int ACC_W = 7 * MAX_BYTES;
    localparam int CNT_W = $clog2(MAX_BYTES + 1);
    localparam int SH_W  = $clog2(ACC_W) + 1;

    logic [ACC_W-1:0] acc_q;
    logic [SH_W-1:0]  shamt;

    always_comb begin
        shamt  = SH_W'(cnt_q) * SH_W'(7);
        acc_nx = acc_q;
        cnt_nx = cnt_q;
        if (push && (cnt_q < CNT_W'(MAX_BYTES))) begin
            acc_nx = acc_q | (ACC_W'(din[6:0]) << shamt);
            cnt_nx = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            acc_q <= acc_nx;
            cnt_q <= cnt_nx;
        end
    end

    // R10: the group counter never runs past the field limit
    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(MAX_BYTES));

endmodule

// File: rtl/brdec_addr_build.sv
module brdec_addr_build
    import brdec_pkg::*;
(
    input  logic [ADDR_ACC_W-1:0] gathered,
    input  logic [2:0]            nbytes,
    input  logic                  alt_mode,
    input  isa_e                  isa,
    input  logic [ADDR_W-1:0]     prev_addr,
    output logic [ADDR_W-1:0]     addr,
    output logic                  exc_follow
);
    logic [5:0]        wid;
    logic [5:0]        wadj;
    logic [WIDE_W-1:0] pay;
    logic [WIDE_W-1:0] shifted;

    always_comb begin
        wid = (6'(nbytes) * 6'd7) - {5'd0, alt_mode};
        pay = {1'b0, gathered} & ((WIDE_W'(1) << wid) - WIDE_W'(1));

        if (alt_mode) exc_follow = (nbytes >= 3'd2) && gathered[wid];
        else          exc_follow = (nbytes == 3'd5) && gathered[ADDR_ACC_W-1];

        unique case (isa)
            ISA_HALF: begin
                shifted = pay & ~WIDE_W'(1);
                wadj    = wid;
            end
            ISA_BYTE: begin
                shifted = (pay & ~WIDE_W'(1)) >> 1;
                wadj    = wid - 6'd1;
            end
            default: begin
                shifted = (pay & ~WIDE_W'(1)) << 1;
                wadj    = wid + 6'd1;
            end
        endcase

        addr = shifted[ADDR_W-1:0] | (prev_addr & upper_mask(wadj));
    end

endmodule

// File: rtl/brdec_exc_fields.sv
module brdec_exc_fields
    import brdec_pkg::*;
#(
    parameter int ACC_W = 28,
    parameter int CNT_W = 3
) (
    input  logic [ACC_W-1:0] raw,
    input  logic [CNT_W-1:0] nbytes,
    output exc_info_t        info
);
    logic [EXC_WORK_W-1:0] v_in;
    logic [EXC_WORK_W-1:0] v;

    always_comb begin
        v_in = EXC_WORK_W'(raw);
        if ((nbytes == CNT_W'(2)) && v_in[13])
            v = (v_in & EXC_WORK_W'(32'h7F)) | ((v_in & EXC_WORK_W'(32'h3F80)) << 7);
        else
            v = v_in;

        info.non_secure = v[0];
        info.num        = {v[11:7], v[4:1]};
        info.cancel     = v[5];
        info.alt_isa    = v[6];
        info.hyp        = v[12];
        info.resume     = v[17:14];
    end

endmodule

// File: rtl/branch_addr_decoder.sv
module branch_addr_decoder
    import brdec_pkg::*;
#(
    parameter int MAX_EXC_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enc_alt,
    input  logic                 ref_load,
    input  logic [ADDR_W-1:0]    ref_addr,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [7:0]           in_byte,
    output logic                 done,
    output logic [ADDR_W-1:0]    branch_addr,
    output logic [1:0]           isa_state,
    output logic                 exc_valid,
    output logic [EXC_NUM_W-1:0] exc_num,
    output logic                 exc_cancel,
    output logic                 exc_alt_isa,
    output logic                 exc_hyp,
    output logic [RESUME_W-1:0]  exc_resume,
    output logic                 exc_non_secure,
    output logic                 err_state,
    output logic                 err_overflow
);
    localparam int A_CNT_W = $clog2(MAX_ADDR_BYTES + 1);
    localparam int E_CNT_W = $clog2(MAX_EXC_BYTES + 1);
    localparam int E_ACC_W = 7 * MAX_EXC_BYTES;

    typedef enum logic {PH_ADDR, PH_EXC} phase_e;

    phase_e              phase_q;
    isa_e                isa_q;
    logic [ADDR_W-1:0]   prev_q;
    logic [ADDR_W-1:0]   addr_q;
    exc_info_t           exc_q;
    logic                done_q, excv_q, errs_q, erro_q;

    logic                fire, last, a_push, e_push, a_clr, e_clr, a_ovf, e_ovf;
    logic [ADDR_ACC_W-1:0] a_acc_nx;
    logic [A_CNT_W-1:0]  a_cnt_q, a_cnt_nx;
    logic [E_ACC_W-1:0]  e_acc_nx;
    logic [E_CNT_W-1:0]  e_cnt_q, e_cnt_nx;
    isa_dec_t            isa_dec;
    logic                fifth, state_bad, exc_follow;
    isa_e                isa_eff;
    logic [ADDR_W-1:0]   new_addr;
    exc_info_t           exc_new;

    assign in_ready = !ref_load;
    assign fire     = in_valid && in_ready;
    assign last     = !in_byte[7];
    assign a_push   = fire && (phase_q == PH_ADDR);
    assign e_push   = fire && (phase_q == PH_EXC);
    assign a_ovf    = a_push && !last && (a_cnt_nx == A_CNT_W'(MAX_ADDR_BYTES));
    assign e_ovf    = e_push && !last && (e_cnt_nx == E_CNT_W'(MAX_EXC_BYTES));
    assign a_clr    = a_push && (last || a_ovf);
    assign e_clr    = e_push && (last || e_ovf);

    assign isa_dec   = decode_isa_byte(in_byte, isa_q);
    assign fifth     = (a_cnt_nx == A_CNT_W'(MAX_ADDR_BYTES));
    assign isa_eff   = fifth ? isa_dec.isa : isa_q;
    assign state_bad = fifth && !isa_dec.ok;

    brdec_gather #(.MAX_BYTES(MAX_ADDR_BYTES)) u_addr_gather (
        .clk(clk), .rst(rst), .clear(a_clr), .push(a_push), .din(in_byte),
        .acc_nx(a_acc_nx), .cnt_q(a_cnt_q), .cnt_nx(a_cnt_nx)
    );

    brdec_gather #(.MAX_BYTES(MAX_EXC_BYTES)) u_exc_gather (
        .clk(clk), .rst(rst), .clear(e_clr), .push(e_push), .din(in_byte),
        .acc_nx(e_acc_nx), .cnt_q(e_cnt_q), .cnt_nx(e_cnt_nx)
    );

    brdec_addr_build u_build (
        .gathered(a_acc_nx), .nbytes(3'(a_cnt_nx)), .alt_mode(enc_alt),
        .isa(isa_eff), .prev_addr(prev_q), .addr(new_addr), .exc_follow(exc_follow)
    );

    brdec_exc_fields #(.ACC_W(E_ACC_W), .CNT_W(E_CNT_W)) u_exc (
        .raw(e_acc_nx), .nbytes(e_cnt_nx), .info(exc_new)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ADDR;
            isa_q   <= ISA_WORD;
            prev_q  <= '0;
            addr_q  <= '0;
            exc_q   <= '0;
            done_q  <= 1'b0;
            excv_q  <= 1'b0;
            errs_q  <= 1'b0;
            erro_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            excv_q <= 1'b0;
            errs_q <= 1'b0;
            erro_q <= 1'b0;
            if (ref_load) prev_q <= ref_addr;
            if (a_push) begin
                if (a_ovf) begin
                    erro_q <= 1'b1;
                end else if (last) begin
                    if (state_bad) begin
                        errs_q <= 1'b1;
                    end else begin
                        prev_q <= new_addr;
                        addr_q <= new_addr;
                        isa_q  <= isa_eff;
                        if (exc_follow) phase_q <= PH_EXC;
                        else begin
                            done_q <= 1'b1;
                            exc_q  <= '0;
                        end
                    end
                end
            end
            if (e_push) begin
                if (e_ovf) begin
                    erro_q  <= 1'b1;
                    phase_q <= PH_ADDR;
                end else if (last) begin
                    exc_q   <= exc_new;
                    excv_q  <= 1'b1;
                    done_q  <= 1'b1;
                    phase_q <= PH_ADDR;
                end
            end
        end
    end

    assign done           = done_q;
    assign branch_addr    = addr_q;
    assign isa_state      = isa_q;
    assign exc_valid      = excv_q;
    assign exc_num        = exc_q.num;
    assign exc_cancel     = exc_q.cancel;
    assign exc_alt_isa    = exc_q.alt_isa;
    assign exc_hyp        = exc_q.hyp;
    assign exc_resume     = exc_q.resume;
    assign exc_non_secure = exc_q.non_secure;
    assign err_state      = errs_q;
    assign err_overflow   = erro_q;

    // R10: at most one outcome strobe per cycle
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err_state, err_overflow}));

    // R8: exception fields only accompany a completion
    assert_excv_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> done);

    // R4: the state moves only on a completed five-byte address
    assert_isa_moves_on_fifth_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(isa_q) |-> $past(a_push && last && fifth));

    // R5: an illegal state byte leaves the state alone
    assert_bad_state_keeps_isa_R5: assert property (@(posedge clk) disable iff (rst)
        err_state |-> $stable(isa_q));

    // R2: a plain completion leaves its target as the new reference
    assert_prev_tracks_R2: assert property (@(posedge clk) disable iff (rst)
        (done && !exc_valid) |-> (prev_q == branch_addr));

    // R10: an overflow leaves both gatherers empty and the block expecting an address
    assert_ovf_idle_R10: assert property (@(posedge clk) disable iff (rst)
        err_overflow |-> (a_cnt_q == '0 && e_cnt_q == '0 && phase_q == PH_ADDR));

endmodule

// File: tb/branch_addr_decoder_tb.sv
`timescale 1ns/1ps
module branch_addr_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_alt = 1'b0;
    logic        ref_load = 1'b0;
    logic [31:0] ref_addr = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = '0;
    logic        done, exc_valid, exc_cancel, exc_alt_isa, exc_hyp, exc_non_secure;
    logic        err_state, err_overflow;
    logic [31:0] branch_addr;
    logic [1:0]  isa_state;
    logic [8:0]  exc_num;
    logic [3:0]  exc_resume;

    int checks = 0;
    int errors = 0;
    logic g_done, g_se, g_ov, g_xv;

    always #2 clk = ~clk;

    branch_addr_decoder u_dut (
        .clk(clk), .rst(rst), .enc_alt(enc_alt), .ref_load(ref_load), .ref_addr(ref_addr),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .done(done), .branch_addr(branch_addr), .isa_state(isa_state),
        .exc_valid(exc_valid), .exc_num(exc_num), .exc_cancel(exc_cancel),
        .exc_alt_isa(exc_alt_isa), .exc_hyp(exc_hyp), .exc_resume(exc_resume),
        .exc_non_secure(exc_non_secure), .err_state(err_state), .err_overflow(err_overflow)
    );

    typedef struct packed {
        logic        alt;
        logic [2:0]  n;
        logic [39:0] bytes;
        logic [1:0]  kind;   // 0 done, 1 state error, 2 overflow
        logic [31:0] addr;
        logic [1:0]  isa;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd1, 40'h00000000_6A, 2'd0, 32'h12345654, 2'd0},
        '{1'b0, 3'd1, 40'h00000000_6A, 2'd0, 32'h123456D4, 2'd0},
        '{1'b0, 3'd5, 40'h10808080_81, 2'd0, 32'h00000000, 2'd1},
        '{1'b0, 3'd1, 40'h00000000_6A, 2'd0, 32'h1234566A, 2'd1},
        '{1'b0, 3'd5, 40'h20808080_84, 2'd0, 32'h00000002, 2'd2},
        '{1'b0, 3'd1, 40'h00000000_10, 2'd0, 32'h12345648, 2'd2},
        '{1'b0, 3'd5, 40'h00808080_81, 2'd1, 32'h00000000, 2'd2},
        '{1'b1, 3'd1, 40'h00000000_6A, 2'd0, 32'h12345675, 2'd2},
        '{1'b0, 3'd5, 40'h08808080_81, 2'd0, 32'h00000000, 2'd0},
        '{1'b0, 3'd5, 40'h80808080_80, 2'd2, 32'h00000000, 2'd0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        g_done = done; g_se = err_state; g_ov = err_overflow; g_xv = exc_valid;
    endtask

    task automatic load_ref(input logic [31:0] a);
        @(negedge clk);
        ref_load = 1'b1;
        ref_addr = a;
        #1;
        chk("R2 in_ready low during load", {63'd0, in_ready}, 64'd0);
        @(negedge clk);
        ref_load = 1'b0;
    endtask

    task automatic five_prefix();
        put_byte(8'h81); put_byte(8'h80); put_byte(8'h80); put_byte(8'h80);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 done", {63'd0, done}, 0);
        chk("R11 errors", {62'd0, err_state, err_overflow}, 0);
        chk("R11 isa", {62'd0, isa_state}, 0);
        chk("R11 in_ready", {63'd0, in_ready}, 1);
        put_byte(8'h6A);
        chk("R11 prev target is zero after reset", {32'd0, branch_addr}, 64'h000000D4);

        // table of packets: R1 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            enc_alt = VEC[i].alt;
            load_ref(32'h12345678);
            for (int k = 0; k < int'(VEC[i].n); k++) put_byte(VEC[i].bytes[8*k +: 8]);
            chk("R1 done strobe", {63'd0, g_done}, {63'd0, VEC[i].kind == 2'd0});
            chk("R5 state error strobe", {63'd0, g_se}, {63'd0, VEC[i].kind == 2'd1});
            chk("R10 overflow strobe", {63'd0, g_ov}, {63'd0, VEC[i].kind == 2'd2});
            if (VEC[i].kind == 2'd0)
                chk("R3 target address", {32'd0, branch_addr}, {32'd0, VEC[i].addr});
            chk("R4 isa state", {62'd0, isa_state}, {62'd0, VEC[i].isa});
        end

        // R2 chaining without reload
        enc_alt = 1'b1;
        load_ref(32'h12345678);
        put_byte(8'h6A);
        chk("R2 first target", {32'd0, branch_addr}, 64'h12345654);
        put_byte(8'h01);
        chk("R2 merge from previous target", {32'd0, branch_addr}, 64'h12345600);

        // R6 alternative encoding with exception field
        load_ref(32'h12345678);
        put_byte(8'h85);
        put_byte(8'h40);
        chk("R6 no done before exception field", {63'd0, g_done}, 0);
        put_byte(8'h00);
        chk("R6 done with exception", {62'd0, g_done, g_xv}, 64'd3);
        chk("R6 address without flag bit", {32'd0, branch_addr}, 64'h12344008);
        chk("R8 zero fields", {48'd0, exc_num, exc_cancel, exc_alt_isa, exc_hyp, exc_non_secure, exc_resume}, 0);

        // R7 R8 original encoding, one-byte exception field
        enc_alt = 1'b0;
        five_prefix(); put_byte(8'h48);
        chk("R7 waits for exception field", {63'd0, g_done}, 0);
        put_byte(8'h7F);
        chk("R7 done with exception", {62'd0, g_done, g_xv}, 64'd3);
        chk("R7 address", {32'd0, branch_addr}, 0);
        chk("R8 number", {55'd0, exc_num}, 64'd15);
        chk("R8 flags ns/cancel/alt/hyp", {60'd0, exc_non_secure, exc_cancel, exc_alt_isa, exc_hyp}, 64'b1110);
        chk("R8 resume", {60'd0, exc_resume}, 0);

        // R8 two bytes without fix-up: hypervisor and high number bits
        five_prefix(); put_byte(8'h48);
        put_byte(8'h83); put_byte(8'h3F);
        chk("R8 high number bits", {55'd0, exc_num}, 64'd497);
        chk("R8 hypervisor", {60'd0, exc_non_secure, exc_cancel, exc_alt_isa, exc_hyp}, 64'b1001);

        // R9 two bytes with bit 13 set
        five_prefix(); put_byte(8'h48);
        put_byte(8'h83); put_byte(8'h45);
        chk("R9 resume after fix-up", {60'd0, exc_resume}, 64'd5);
        chk("R9 number after fix-up", {55'd0, exc_num}, 64'd1);
        chk("R9 hyp after fix-up", {63'd0, exc_hyp}, 0);

        // R10 exception overflow and recovery
        enc_alt = 1'b1;
        load_ref(32'h12345678);
        put_byte(8'h85); put_byte(8'h40);
        put_byte(8'h80); put_byte(8'h80); put_byte(8'h80);
        chk("R10 no overflow on third exception byte", {63'd0, g_ov}, 0);
        put_byte(8'h80);
        chk("R10 overflow on fourth exception byte", {62'd0, g_ov, g_done}, 64'd2);
        load_ref(32'h12345678);
        put_byte(8'h6A);
        chk("R10 recovery packet done", {63'd0, g_done}, 1);
        chk("R10 recovery address", {32'd0, branch_addr}, 64'h12345654);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule